// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects eight interrupt request lines and presents one interrupt request to a processor. When the processor acknowledges, the block returns an 8-bit vector for the most urgent unmasked request and records that request as in service. Software talks to the block through a byte-wide port pair chosen by one address bit, the "even" port (address 0) and the "odd" port (address 1), with separate read and write strobes.

Before it raises any interrupt, the block must be set up by a short sequence of writes. A start word on the even port opens the sequence. The odd-port writes that follow set the vector base, then optionally the cascade wiring, then optionally a mode word. After setup, odd-port writes and reads reach the mask register, even-port reads return the in-service register, and an even-port write of 0x20 retires the most urgent in-service request. Priority is fixed, with line 0 the most urgent. The cascade wiring byte and the master/slave role are decoded and brought out for the neighbouring logic that builds the cascade link.

Top module: `pic_ctrl8`

## Requirements
- R1: After reset the interrupt output is low, the acknowledge vector is 0x00 and both read ports return 0x00. Until a setup sequence has finished, the interrupt output stays low whatever the request lines do, and odd-port writes have no effect.
- R2: An even-port write with bit 4 set starts setup. In that start word, bit 1 set means single (no cascade word) and bit 0 set means a mode word follows. The next odd write is the vector base, then the cascade word if bit 1 was clear, then the mode word if bit 0 was set. Any later odd write reaches the mask register.
- R3: A request on line N is acknowledged with vector base + N (8-bit sum). The vector is valid from the clock edge after the acknowledge cycle and is held until the next acknowledge.
- R4: The mask register is written and read on the odd port after setup. Bit N set keeps line N from raising the interrupt output or being granted. Clearing the bit lets a held request through.
- R5: When several requests are eligible, the acknowledge grants the lowest-numbered line.
- R6: The interrupt output is high only when an unmasked pending request has a lower line number than every bit in service. A more urgent request can therefore nest over one being serviced, and a less urgent one waits.
- R7: After setup, an even-port write of exactly 0x20 clears the lowest-numbered in-service bit. Other even-port writes with bit 4 clear leave the in-service register unchanged. An even-port read returns the in-service register.
- R8: The cascade word is output unchanged as the cascade configuration byte: a line bitmask on a master, a small binary identity on a slave. The role output is 1 (master) unless mode bit 3 (buffered) is set, in which case it equals mode bit 2. For example, 0x0D gives master and 0x09 gives slave.
- R9: Start-word bit 3 selects level mode (1) or edge mode (0). In edge mode a rising edge is latched as pending until it is acknowledged, even if the line drops again. In level mode a request is pending exactly while its line is high.
- R10: Starting setup clears the mask, in-service, pending edge requests, cascade word and mode word. A line that is already high when setup starts is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 1 | Port select: 0 even port, 1 odd port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: mask (odd) or in-service (even) |
| irq_in | input | 8 | Request lines, line 0 most urgent |
| int_out | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse, one cycle |
| ack_vector | output | 8 | Vector of the most recent acknowledge |
| casc_master | output | 1 | Role decoded from the mode word: 1 master, 0 slave |
| casc_cfg | output | 8 | Cascade word as written |

## Verification
The bench goes after the setup skips: a single controller that still waits for a cascade word, or one that treats the mode word as the mask, would show the wrong mask readback. It nests a more urgent request over one in service and parks a less urgent one behind it. A design that compared against the pending requests rather than the in-service bits would raise the interrupt too early or never nest. It checks that end-of-interrupt retires the lowest in-service bit and that a near-miss command does nothing. It also re-runs setup with a request still in service and a line still high. A design that did not clear state there would keep the old in-service bit or invent an edge. Edge latching of a one-cycle pulse and level requests that reappear after end-of-interrupt separate the two trigger modes.

// File: rtl/pic_pkg.sv
package pic_pkg;
  // setup sequencer states
  typedef enum logic [2:0] {
    ST_UNINIT,
    ST_BASE,
    ST_CASC,
    ST_MODE,
    ST_RUN
  } seq_state_t;

  // start-word flag positions
  localparam int unsigned START_BIT  = 4;
  localparam int unsigned LEVEL_BIT  = 3;
  localparam int unsigned SINGLE_BIT = 1;
  localparam int unsigned NEED4_BIT  = 0;
  // mode-word flag positions
  localparam int unsigned BUF_BIT    = 3;
  localparam int unsigned MASTER_BIT = 2;
  // non-specific end-of-interrupt command
  localparam logic [7:0] EOI_CMD = 8'h20;
endpackage

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
  import pic_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              ready,
  output logic              init_start,
  output logic              eoi,
  output logic              level_mode,
  output logic [DATA_W-1:0] vec_base,
  output logic [NUM_IRQ-1:0] irq_mask,
  output logic [DATA_W-1:0] casc_word,
  output logic [DATA_W-1:0] mode_word
);
  seq_state_t         state_q, state_d;
  logic               single_q, single_d, need4_q, need4_d, level_q, level_d;
  logic [DATA_W-1:0]  base_q, base_d, casc_q, casc_d, mode_q, mode_d;
  logic [NUM_IRQ-1:0] mask_q, mask_d;
  logic               wr_even, wr_odd, upd_en;

  assign wr_even    = bus_wr & ~bus_addr;
  assign wr_odd     = bus_wr & bus_addr;
  assign init_start = wr_even & bus_wdata[START_BIT];
  assign ready      = (state_q == ST_RUN);
  assign eoi        = wr_even & ready & (bus_wdata == DATA_W'(EOI_CMD));
  assign upd_en     = init_start | wr_odd;

  always_comb begin
    state_d  = state_q;
    single_d = single_q;
    need4_d  = need4_q;
    level_d  = level_q;
    base_d   = base_q;
    casc_d   = casc_q;
    mode_d   = mode_q;
    mask_d   = mask_q;
    if (init_start) begin
      state_d  = ST_BASE;
      single_d = bus_wdata[SINGLE_BIT];
      need4_d  = bus_wdata[NEED4_BIT];
      level_d  = bus_wdata[LEVEL_BIT];
      casc_d   = '0;
      mode_d   = '0;
      mask_d   = '0;
    end else if (wr_odd) begin
      unique case (state_q)
        ST_BASE: begin
          base_d = bus_wdata;
          if (!single_q)    state_d = ST_CASC;
          else if (need4_q) state_d = ST_MODE;
          else              state_d = ST_RUN;
        end
        ST_CASC: begin
          casc_d  = bus_wdata;
          state_d = need4_q ? ST_MODE : ST_RUN;
        end
        ST_MODE: begin
          mode_d  = bus_wdata;
          state_d = ST_RUN;
        end
        ST_RUN:  mask_d = bus_wdata[NUM_IRQ-1:0];
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_UNINIT;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      level_q  <= 1'b0;
      base_q   <= '0;
      casc_q   <= '0;
      mode_q   <= '0;
      mask_q   <= '0;
    end else if (upd_en) begin
      state_q  <= state_d;
      single_q <= single_d;
      need4_q  <= need4_d;
      level_q  <= level_d;
      base_q   <= base_d;
      casc_q   <= casc_d;
      mode_q   <= mode_d;
      mask_q   <= mask_d;
    end
  end

  assign level_mode = level_q;
  assign vec_base   = base_q;
  assign irq_mask   = mask_q;
  assign casc_word  = casc_q;
  assign mode_word  = mode_q;
endmodule

// File: rtl/pic_req_reg.sv
module pic_req_reg #(
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               level_mode,
  input  logic               clear_all,
  input  logic [NUM_IRQ-1:0] take,
  output logic [NUM_IRQ-1:0] pending
);
  logic [NUM_IRQ-1:0] prev_q, lvl_q, edge_q, edge_d;

  always_comb begin
    if (clear_all) edge_d = '0;
    else           edge_d = (edge_q & ~take) | (irq_in & ~prev_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lvl_q  <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= irq_in;
      lvl_q  <= irq_in;
      edge_q <= edge_d;
    end
  end

  assign pending = level_mode ? lvl_q : edge_q;
endmodule

// File: rtl/pic_service.sv
module pic_service #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ready,
  input  logic               clear_all,
  input  logic               eoi,
  input  logic               ack,
  input  logic [NUM_IRQ-1:0] pending,
  input  logic [NUM_IRQ-1:0] irq_mask,
  input  logic [DATA_W-1:0]  vec_base,
  output logic               int_req,
  output logic [NUM_IRQ-1:0] isr,
  output logic [NUM_IRQ-1:0] take,
  output logic [DATA_W-1:0]  ack_vector
);
  localparam int unsigned IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  function automatic logic [NUM_IRQ-1:0] low1(input logic [NUM_IRQ-1:0] v);
    return v & (~v + NUM_IRQ'(1));
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [NUM_IRQ-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_IRQ; i++) if (oh[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [NUM_IRQ-1:0] isr_q, isr_d, allowed, eligible, grant;
  logic [DATA_W-1:0]  vec_q, vec_d;
  logic [IDX_W-1:0]   grant_idx;
  logic               do_ack, isr_en;

  assign allowed   = (isr_q == '0) ? '1 : (low1(isr_q) - NUM_IRQ'(1));
  assign eligible  = pending & ~irq_mask & allowed;
  assign grant     = low1(eligible);
  assign do_ack    = ack & ready;
  assign grant_idx = (grant != '0) ? idx_of(grant) : IDX_W'(NUM_IRQ - 1);
  assign isr_en    = clear_all | do_ack | eoi;

  always_comb begin
    if (clear_all)   isr_d = '0;
    else if (do_ack) isr_d = isr_q | grant;
    else if (eoi)    isr_d = isr_q & ~low1(isr_q);
    else             isr_d = isr_q;
    vec_d = vec_base + DATA_W'(grant_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      if (isr_en) isr_q <= isr_d;
      if (do_ack) vec_q <= vec_d;
    end
  end

  assign int_req    = ready & (|eligible);
  assign take       = do_ack ? grant : '0;
  assign isr        = isr_q;
  assign ack_vector = vec_q;
endmodule

// File: rtl/pic_ctrl8.sv
module pic_ctrl8
  import pic_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic               int_out,
  input  logic               int_ack,
  output logic [DATA_W-1:0]  ack_vector,
  output logic               casc_master,
  output logic [DATA_W-1:0]  casc_cfg
);
  logic               rst_meta_q, rst_core_n;
  logic               ready, init_start, eoi, level_mode;
  logic [DATA_W-1:0]  vec_base, mode_word;
  logic [NUM_IRQ-1:0] irq_mask, pending, isr, take;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  pic_cmd_seq #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ready      (ready),
    .init_start (init_start),
    .eoi        (eoi),
    .level_mode (level_mode),
    .vec_base   (vec_base),
    .irq_mask   (irq_mask),
    .casc_word  (casc_cfg),
    .mode_word  (mode_word)
  );

  pic_req_reg #(.NUM_IRQ(NUM_IRQ)) u_req (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .irq_in     (irq_in),
    .level_mode (level_mode),
    .clear_all  (init_start),
    .take       (take),
    .pending    (pending)
  );

  pic_service #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_svc (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ready      (ready),
    .clear_all  (init_start),
    .eoi        (eoi),
    .ack        (int_ack),
    .pending    (pending),
    .irq_mask   (irq_mask),
    .vec_base   (vec_base),
    .int_req    (int_out),
    .isr        (isr),
    .take       (take),
    .ack_vector (ack_vector)
  );

  assign casc_master = mode_word[BUF_BIT] ? mode_word[MASTER_BIT] : 1'b1;

  always_comb begin
    if (!bus_rd)       bus_rdata = '0;
    else if (bus_addr) bus_rdata = DATA_W'(irq_mask);
    else               bus_rdata = DATA_W'(isr);
  end
endmodule

// File: rtl/pic_ctrl8_chk.sv
module pic_ctrl8_chk #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               int_out,
  input logic               int_ack,
  input logic               bus_wr,
  input logic               ready,
  input logic               init_start,
  input logic               eoi,
  input logic [NUM_IRQ-1:0] isr,
  input logic [NUM_IRQ-1:0] irq_mask,
  input logic [NUM_IRQ-1:0] pending,
  input logic [DATA_W-1:0]  vec_base,
  input logic [DATA_W-1:0]  ack_vector
);
  // R1
  no_int_before_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  // R4
  int_needs_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(pending & ~irq_mask)));

  // R3
  vector_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && ready) |=> (DATA_W'(ack_vector - vec_base) < DATA_W'(NUM_IRQ)));

  // R6
  ack_adds_one_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && int_out && !bus_wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

  // R7
  eoi_retires_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !int_ack && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  // R10
  setup_clears_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start |=> (isr == '0 && irq_mask == '0));
endmodule

bind pic_ctrl8 pic_ctrl8_chk #(.DATA_W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .int_out    (int_out),
  .int_ack    (int_ack),
  .bus_wr     (bus_wr),
  .ready      (ready),
  .init_start (init_start),
  .eoi        (eoi),
  .isr        (isr),
  .irq_mask   (irq_mask),
  .pending    (pending),
  .vec_base   (vec_base),
  .ack_vector (ack_vector)
);

// File: tb/tb_pic_ctrl8.sv
`timescale 1ns/1ps
module tb_pic_ctrl8;
  logic       clk, rst_n, bus_addr, bus_wr, bus_rd, int_ack, int_out, casc_master;
  logic [7:0] bus_wdata, bus_rdata, irq_in, ack_vector, casc_cfg;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  pic_ctrl8 dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .int_out(int_out),
    .int_ack(int_ack), .ack_vector(ack_vector), .casc_master(casc_master), .casc_cfg(casc_cfg)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0;
    v = ack_vector;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic setup4(input logic [7:0] w1, w2, w3, w4);
    wr(1'b0, w1); wr(1'b1, w2); wr(1'b1, w3); wr(1'b1, w4);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 int_out after reset", {7'd0, int_out}, 8'h00);
    chk("R1 vector after reset", ack_vector, 8'h00);
    rd(1'b1, d); chk("R1 odd read after reset", d, 8'h00);
    rd(1'b0, d); chk("R1 even read after reset", d, 8'h00);
    lines(8'hFF);
    chk("R1 no int before setup", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h55);
    rd(1'b1, d); chk("R1 odd write ignored before setup", d, 8'h00);
    lines(8'h00);
  endtask

  task automatic t_master;
    logic [7:0] d, v;
    setup4(8'h11, 8'h20, 8'h04, 8'h0D);
    chk("R8 master cascade byte", casc_cfg, 8'h04);
    chk("R8 master role", {7'd0, casc_master}, 8'h01);
    rd(1'b1, d); chk("R4 mask zero after setup", d, 8'h00);
    lines(8'h08);
    chk("R6 int on line3", {7'd0, int_out}, 8'h01);
    ack(v); chk("R3 vector line3", v, 8'h23);
    rd(1'b0, d); chk("R7 isr after ack3", d, 8'h08);
    chk("R9 edge consumed while line high", {7'd0, int_out}, 8'h00);
    lines(8'h28);
    chk("R6 line5 waits behind 3", {7'd0, int_out}, 8'h00);
    lines(8'h2A);
    chk("R6 line1 nests over 3", {7'd0, int_out}, 8'h01);
    ack(v); chk("R3 vector line1", v, 8'h21);
    rd(1'b0, d); chk("R6 isr nested", d, 8'h0A);
    wr(1'b0, 8'h60);
    rd(1'b0, d); chk("R7 other command ignored", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R7 eoi clears line1", d, 8'h08);
    chk("R6 line5 still blocked", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    rd(1'b0, d); chk("R7 eoi clears line3", d, 8'h00);
    chk("R6 line5 now raised", {7'd0, int_out}, 8'h01);
    ack(v); chk("R3 vector line5", v, 8'h25);
    wr(1'b0, 8'h20);
    lines(8'h00); lines(8'h90);
    ack(v); chk("R5 line4 before line7", v, 8'h24);
    wr(1'b0, 8'h20);
    ack(v); chk("R5 line7 next", v, 8'h27);
    wr(1'b0, 8'h20);
    lines(8'h00);
    wr(1'b1, 8'h01);
    rd(1'b1, d); chk("R4 mask readback", d, 8'h01);
    lines(8'h03);
    ack(v); chk("R4 masked line0 skipped", v, 8'h21);
    wr(1'b0, 8'h20);
    chk("R4 masked line0 no int", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    chk("R4 unmask releases line0", {7'd0, int_out}, 8'h01);
    ack(v); chk("R4 vector line0", v, 8'h20);
    wr(1'b0, 8'h20);
    lines(8'h00);
    @(negedge clk); irq_in = 8'h40;
    @(negedge clk); irq_in = 8'h00;
    @(negedge clk);
    chk("R9 edge pulse latched", {7'd0, int_out}, 8'h01);
    ack(v); chk("R9 vector latched pulse", v, 8'h26);
    wr(1'b0, 8'h20);
    lines(8'h04);
    ack(v); chk("R3 vector line2", v, 8'h22);
    wr(1'b1, 8'hFF);
  endtask

  task automatic t_slave;
    logic [7:0] d, v;
    setup4(8'h11, 8'h70, 8'h02, 8'h09);
    chk("R8 slave identity", casc_cfg, 8'h02);
    chk("R8 slave role", {7'd0, casc_master}, 8'h00);
    rd(1'b0, d); chk("R10 isr cleared by setup", d, 8'h00);
    rd(1'b1, d); chk("R10 mask cleared by setup", d, 8'h00);
    chk("R10 held line not an edge", {7'd0, int_out}, 8'h00);
    lines(8'h00); lines(8'h04);
    ack(v); chk("R3 slave vector line2", v, 8'h72);
    wr(1'b0, 8'h20);
    lines(8'h00);
  endtask

  task automatic t_single;
    logic [7:0] d, v;
    wr(1'b0, 8'h13); wr(1'b1, 8'h50); wr(1'b1, 8'h01); wr(1'b1, 8'h0F);
    rd(1'b1, d); chk("R2 single skips cascade word", d, 8'h0F);
    chk("R2 cascade byte untouched", casc_cfg, 8'h00);
    chk("R8 unbuffered is master", {7'd0, casc_master}, 8'h01);
    lines(8'h10);
    ack(v); chk("R3 vector single", v, 8'h54);
    wr(1'b0, 8'h20);
    lines(8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d, v;
    wr(1'b0, 8'h1A); wr(1'b1, 8'h40); wr(1'b1, 8'h80);
    rd(1'b1, d); chk("R2 no mode word, direct mask", d, 8'h80);
    lines(8'h04);
    chk("R9 level raises int", {7'd0, int_out}, 8'h01);
    ack(v); chk("R3 level vector", v, 8'h42);
    chk("R6 in service blocks same line", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20);
    chk("R9 level re-requests after eoi", {7'd0, int_out}, 8'h01);
    lines(8'h00);
    chk("R9 level drop clears request", {7'd0, int_out}, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; irq_in = 8'h00; int_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master();
    t_slave();
    t_single();
    t_level();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule